// File: doc/BRIEF.md
# Clock Ratio Classifier and Mute Sequencer

This block watches a frame clock (one period per audio sample) from inside the master-clock domain and measures how many master-clock cycles each frame period lasts. It sorts the measurement into one of five legal ratios, or into "invalid", and reports whether the legal ratio is a base-rate or a high-rate one. A ratio is only taken over after it has read the same on two frames in a row. This keeps a single disturbed frame from changing the reported class.

The same block sequences the analog output stage. While reset is held, the stage is treated as powered down: the output is disconnected, with the clamp released and the ramp at zero. After reset is released and a legal ratio has been locked, the output is clamped to ground for a set number of frames. It is then ramped up one step per frame toward the quiescent level, and audio runs once the ramp is full. A mute-control output for an external mute circuit stays high except in the run state. It also rises whenever the latest measurement is invalid or a soft mute is requested. When the locked ratio changes, the sequence starts again from the clamp state. When the lock moves to invalid, the sequence returns to idle.

Top module: `clk_ratio_mute_ctl`

## Requirements
- R1: A period of 256, 384 or 512 master cycles, read on two consecutive frames, sets `ratio_code` to 3, 4 or 5 respectively, with `high_rate` = 0.
- R2: A period of 128 or 192 master cycles, read on two consecutive frames, sets `ratio_code` to 1 or 2, with `high_rate` = 1.
- R3: A period within TOL (default 2) master cycles of a legal ratio is treated as that ratio. A period that is TOL+1 or more away from every legal ratio is invalid (code 0).
- R4: `ratio_code` changes only after two consecutive measurements agree on a code that differs from the current one. A single differing reading leaves it unchanged.
- R5: After an invalid measurement, `mute_out` is high until a later measurement is valid, even if `ratio_code` is unchanged.
- R6: While `rst` is high, the outputs are `ratio_code` = 0, `high_rate` = 0, `mute_out` = 1, `clamp_en` = 0 and `ramp_lvl` = 0. After release, the sequence starts in idle.
- R7: In idle and for CLAMP_FRAMES frame periods after a legal ratio is locked, `clamp_en` = 1, `ramp_lvl` = 0 and `mute_out` = 1.
- R8: After the clamp, `clamp_en` = 0 and `ramp_lvl` rises by one per frame period up to all ones. At that point the run state begins, `mute_out` goes low, and `ramp_lvl` stays at all ones.
- R9: When the lock moves to a different legal code, the sequence restarts at the clamp state with `ramp_lvl` = 0.
- R10: `soft_mute` = 1 forces `mute_out` high without changing the sequence state, `ramp_lvl` or `clamp_en`.
- R11: When the lock moves to invalid, the block returns to idle (`clamp_en` = 1, `ramp_lvl` = 0, `mute_out` = 1).
- R12: If no frame-clock rising edge arrives for 2^CNT_W master cycles, an invalid measurement is recorded. Two such windows in a row unlock the ratio to code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset / power-down request |
| fclk | input | 1 | Frame clock, sampled asynchronously and synchronized internally |
| soft_mute | input | 1 | Soft mute request |
| ratio_code | output | 3 | Locked ratio: 0 invalid, 1=128, 2=192, 3=256, 4=384, 5=512 |
| high_rate | output | 1 | 1 when the locked ratio is a high-rate one |
| clamp_en | output | 1 | Clamp the output stage to ground |
| ramp_lvl | output | RAMP_W | Output ramp level toward the quiescent voltage |
| mute_out | output | 1 | External mute control, active high |

## Verification
A frame-clock edge can advance the clamp count or the ramp in the same cycle window in which the ratio filter accepts a new code. The accepted change must win, so that the sequence restarts rather than advancing. The bench provokes this by switching the ratio from 384 to 128 while the clamp count is already in progress. It judges the outcome by the exact frame in which the run state is reached: eleven frames after the new lock, not earlier. A second overlap is soft mute or an invalid single reading arriving while the ramp is full. There, the bench checks that `mute_out` rises while `ramp_lvl` and `ratio_code` stay untouched.

// File: rtl/ckr_pkg.sv
`timescale 1ns/1ps
package ckr_pkg;

  typedef enum logic [2:0] {
    RC_NONE = 3'd0,
    RC_128  = 3'd1,
    RC_192  = 3'd2,
    RC_256  = 3'd3,
    RC_384  = 3'd4,
    RC_512  = 3'd5
  } ratio_code_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_CLAMP = 2'd1,
    SQ_RAMP  = 2'd2,
    SQ_RUN   = 2'd3
  } seq_state_t;

  localparam int NUM_RATIOS = 5;

  // Nominal master cycles per frame for legal code index i (code = i + 1).
  function automatic int ratio_nominal(input int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      default: return 512;
    endcase
  endfunction

  function automatic logic code_is_high(input ratio_code_t c);
    return (c == RC_128) || (c == RC_192);
  endfunction

endpackage

// File: rtl/ckr_frame_meter.sv
`timescale 1ns/1ps
module ckr_frame_meter #(
  parameter int CNT_W = 10,
  parameter int TOL   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fclk,
  output logic                 meas_vld,
  output ckr_pkg::ratio_code_t meas_code,
  output logic                 frame_tick
);
  import ckr_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]       sync_q;
  logic             fedge;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic [CNT_W:0]   period;
  logic             stall;
  logic [NUM_RATIOS-1:0] hit;
  ratio_code_t      code_d;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], fclk};
  end

  assign fedge  = sync_q[1] & ~sync_q[2];
  assign period = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign stall  = (cnt_q == CNT_MAX) && !fedge;

  // One tolerance window per legal ratio.
  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
    localparam int NOM = ratio_nominal(g);
    assign hit[g] = (int'(period) >= NOM - TOL) && (int'(period) <= NOM + TOL);
  end

  always_comb begin
    code_d = RC_NONE;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hit[i]) code_d = ratio_code_t'(3'(i + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      meas_vld   <= 1'b0;
      meas_code  <= RC_NONE;
      frame_tick <= 1'b0;
    end else begin
      meas_vld   <= 1'b0;
      frame_tick <= 1'b0;
      if (fedge) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
        if (armed_q) begin
          meas_vld   <= 1'b1;
          frame_tick <= 1'b1;
          meas_code  <= code_d;
        end
      end else if (stall) begin
        cnt_q     <= '0;
        armed_q   <= 1'b0;
        meas_vld  <= 1'b1;
        meas_code <= RC_NONE;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R12: a stall report never comes with a frame tick
  a_r12_stall_no_tick: assert property (@(posedge clk) disable iff (rst)
    (meas_vld && !frame_tick) |-> (meas_code == RC_NONE));

endmodule

// File: rtl/ckr_ratio_filter.sv
`timescale 1ns/1ps
module ckr_ratio_filter (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 meas_vld,
  input  ckr_pkg::ratio_code_t meas_code,
  output ckr_pkg::ratio_code_t acc_code,
  output logic                 high_rate,
  output logic                 acc_chg,
  output logic                 raw_bad
);
  import ckr_pkg::*;

  ratio_code_t prev_q;
  logic        prev_vld_q;
  logic        agree;

  assign agree = meas_vld && prev_vld_q && (meas_code == prev_q) && (meas_code != acc_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= RC_NONE;
      prev_vld_q <= 1'b0;
      acc_code   <= RC_NONE;
      high_rate  <= 1'b0;
      acc_chg    <= 1'b0;
      raw_bad    <= 1'b1;
    end else begin
      acc_chg <= 1'b0;
      if (meas_vld) begin
        prev_q     <= meas_code;
        prev_vld_q <= 1'b1;
        raw_bad    <= (meas_code == RC_NONE);
      end
      if (agree) begin
        acc_code  <= meas_code;
        high_rate <= code_is_high(meas_code);
        acc_chg   <= 1'b1;
      end
    end
  end

  // R4: the locked code only moves in the cycle after a measurement
  a_r4_move_on_meas: assert property (@(posedge clk) disable iff (rst)
    (acc_code != $past(acc_code)) |-> $past(meas_vld));

endmodule

// File: rtl/ckr_mute_seq.sv
`timescale 1ns/1ps
module ckr_mute_seq #(
  parameter int CLAMP_FRAMES = 1000,
  parameter int RAMP_W       = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_tick,
  input  logic                 acc_chg,
  input  ckr_pkg::ratio_code_t acc_code,
  input  logic                 raw_bad,
  input  logic                 soft_mute,
  output logic                 clamp_q,
  output logic [RAMP_W-1:0]    ramp_q,
  output logic                 mute_q
);
  import ckr_pkg::*;

  localparam int DLY_W = (CLAMP_FRAMES > 1) ? $clog2(CLAMP_FRAMES) : 1;
  localparam logic [DLY_W-1:0]  DLY_LAST = DLY_W'(CLAMP_FRAMES - 1);
  localparam logic [RAMP_W-1:0] RAMP_MAX = '1;

  seq_state_t        st_q, st_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic [RAMP_W-1:0] ramp_d;

  always_comb begin
    st_d   = st_q;
    dly_d  = dly_q;
    ramp_d = ramp_q;
    if (acc_chg) begin
      dly_d  = '0;
      ramp_d = '0;
      st_d   = (acc_code == RC_NONE) ? SQ_IDLE : SQ_CLAMP;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          ramp_d = '0;
          dly_d  = '0;
        end
        SQ_CLAMP: begin
          if (frame_tick) begin
            if (dly_q == DLY_LAST) begin
              st_d  = SQ_RAMP;
              dly_d = '0;
            end else begin
              dly_d = dly_q + 1'b1;
            end
          end
        end
        SQ_RAMP: begin
          if (frame_tick) begin
            ramp_d = ramp_q + 1'b1;
            if (ramp_q == RAMP_MAX - 1'b1) st_d = SQ_RUN;
          end
        end
        default: st_d = SQ_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_IDLE;
      dly_q   <= '0;
      ramp_q  <= '0;
      clamp_q <= 1'b0;
      mute_q  <= 1'b1;
    end else begin
      st_q    <= st_d;
      dly_q   <= dly_d;
      ramp_q  <= ramp_d;
      clamp_q <= (st_d == SQ_IDLE) || (st_d == SQ_CLAMP);
      mute_q  <= (st_d != SQ_RUN) || soft_mute || raw_bad;
    end
  end

  // R8: the ramp only steps up by one or restarts from zero
  a_r8_ramp_step: assert property (@(posedge clk) disable iff (rst)
    (ramp_q != $past(ramp_q)) |-> ((ramp_q == $past(ramp_q) + 1'b1) || (ramp_q == '0)));

  // R8: audio is unmuted only with the ramp at full scale
  a_r8_unmute_full: assert property (@(posedge clk) disable iff (rst)
    !mute_q |-> (ramp_q == RAMP_MAX));

  // R7: while clamped the ramp is at zero and the mute line is high
  a_r7_clamp_quiet: assert property (@(posedge clk) disable iff (rst)
    clamp_q |-> ((ramp_q == '0) && mute_q));

endmodule

// File: rtl/clk_ratio_mute_ctl.sv
`timescale 1ns/1ps
module clk_ratio_mute_ctl #(
  parameter int CNT_W        = 10,
  parameter int TOL          = 2,
  parameter int CLAMP_FRAMES = 1000,
  parameter int RAMP_W       = 14
) (
  input  logic              mclk,
  input  logic              rst,
  input  logic              fclk,
  input  logic              soft_mute,
  output logic [2:0]        ratio_code,
  output logic              high_rate,
  output logic              clamp_en,
  output logic [RAMP_W-1:0] ramp_lvl,
  output logic              mute_out
);
  import ckr_pkg::*;

  logic        meas_vld;
  ratio_code_t meas_code;
  logic        frame_tick;
  ratio_code_t acc_code;
  logic        acc_chg;
  logic        raw_bad;

  ckr_frame_meter #(.CNT_W(CNT_W), .TOL(TOL)) u_meter (
    .clk        (mclk),
    .rst        (rst),
    .fclk       (fclk),
    .meas_vld   (meas_vld),
    .meas_code  (meas_code),
    .frame_tick (frame_tick)
  );

  ckr_ratio_filter u_filter (
    .clk       (mclk),
    .rst       (rst),
    .meas_vld  (meas_vld),
    .meas_code (meas_code),
    .acc_code  (acc_code),
    .high_rate (high_rate),
    .acc_chg   (acc_chg),
    .raw_bad   (raw_bad)
  );

  ckr_mute_seq #(.CLAMP_FRAMES(CLAMP_FRAMES), .RAMP_W(RAMP_W)) u_seq (
    .clk        (mclk),
    .rst        (rst),
    .frame_tick (frame_tick),
    .acc_chg    (acc_chg),
    .acc_code   (acc_code),
    .raw_bad    (raw_bad),
    .soft_mute  (soft_mute),
    .clamp_q    (clamp_en),
    .ramp_q     (ramp_lvl),
    .mute_q     (mute_out)
  );

  assign ratio_code = acc_code;

  // R6: one cycle into reset every output is at its power-down value
  a_r6_reset_quiet: assert property (@(posedge mclk)
    rst |=> (mute_out && !clamp_en && (ramp_lvl == '0) && (ratio_code == 3'd0) && !high_rate));

  // R5: unmuted output always has a locked legal ratio
  a_r5_unmute_locked: assert property (@(posedge mclk) disable iff (rst)
    !mute_out |-> (ratio_code != 3'd0));

  // R2: the high-rate flag goes with codes 1 and 2 only
  a_r2_high_codes: assert property (@(posedge mclk) disable iff (rst)
    high_rate |-> ((ratio_code == 3'd1) || (ratio_code == 3'd2)));

endmodule

// File: tb/clk_ratio_mute_ctl_tb_top.sv
`timescale 1ns/1ps
module clk_ratio_mute_ctl_tb_top;

  localparam int RW = 3;

  logic          mclk = 1'b0;
  logic          rst = 1'b1;
  logic          fclk = 1'b0;
  logic          soft_mute = 1'b0;
  logic [2:0]    ratio_code;
  logic          high_rate;
  logic          clamp_en;
  logic [RW-1:0] ramp_lvl;
  logic          mute_out;

  always #2.5 mclk = ~mclk;

  clk_ratio_mute_ctl #(.CNT_W(10), .TOL(2), .CLAMP_FRAMES(4), .RAMP_W(RW)) dut_i (
    .mclk       (mclk),
    .rst        (rst),
    .fclk       (fclk),
    .soft_mute  (soft_mute),
    .ratio_code (ratio_code),
    .high_rate  (high_rate),
    .clamp_en   (clamp_en),
    .ramp_lvl   (ramp_lvl),
    .mute_out   (mute_out)
  );

  typedef struct {
    string tag;
    int    code;
    int    mode;
    int    mute;
    int    clamp;
    int    ramp;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  function automatic exp_t mk(string t, int c, int m, int mu, int cl, int r);
    exp_t e;
    e.tag = t; e.code = c; e.mode = m; e.mute = mu; e.clamp = cl; e.ramp = r;
    return e;
  endfunction

  task automatic cmp(string tag, string fld, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, fld, act, expv);
    end
  endtask

  // driver side: push the expected item, wake the monitor
  task automatic expect_now(exp_t e);
    q.push_back(e);
    ->chk_ev;
  endtask

  // monitor: pop and compare against the outputs at this (falling-edge) instant
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "ratio_code", int'(ratio_code), e.code);
        cmp(e.tag, "high_rate",  int'(high_rate),  e.mode);
        cmp(e.tag, "mute_out",   int'(mute_out),   e.mute);
        cmp(e.tag, "clamp_en",   int'(clamp_en),   e.clamp);
        cmp(e.tag, "ramp_lvl",   int'(ramp_lvl),   e.ramp);
      end
    end
  end

  // one frame of p master cycles; optional check in its middle
  task automatic frm(int p, bit chk, exp_t e);
    fclk = 1'b1;
    repeat (p / 2) @(negedge mclk);
    if (chk) expect_now(e);
    fclk = 1'b0;
    repeat (p - p / 2) @(negedge mclk);
  endtask

  initial begin
    exp_t nx;
    nx = mk("", 0, 0, 0, 0, 0);
    repeat (6) @(negedge mclk);
    expect_now(mk("R6 held in reset", 0, 0, 1, 0, 0));
    rst = 1'b0;
    frm(256, 1, mk("R7 idle clamp before lock", 0, 0, 1, 1, 0));
    frm(256, 1, mk("R4 one reading does not lock", 0, 0, 1, 1, 0));
    frm(256, 1, mk("R1 lock 256", 3, 0, 1, 1, 0));
    frm(256, 0, nx);
    frm(256, 0, nx);
    frm(256, 1, mk("R7 clamp held", 3, 0, 1, 1, 0));
    frm(256, 1, mk("R7 clamp ends", 3, 0, 1, 0, 0));
    frm(256, 1, mk("R8 first ramp step", 3, 0, 1, 0, 1));
    for (int i = 0; i < 5; i++) frm(256, 0, nx);
    frm(256, 1, mk("R8 ramp full, run", 3, 0, 0, 0, 7));
    frm(256, 1, mk("R8 ramp saturates", 3, 0, 0, 0, 7));
    frm(258, 0, nx);
    frm(256, 1, mk("R3 plus two accepted", 3, 0, 0, 0, 7));
    frm(254, 0, nx);
    frm(256, 1, mk("R3 minus two accepted", 3, 0, 0, 0, 7));
    frm(259, 0, nx);
    frm(256, 1, mk("R5 R3 plus three mutes", 3, 0, 1, 0, 7));
    frm(256, 1, mk("R5 valid reading unmutes", 3, 0, 0, 0, 7));
    soft_mute = 1'b1;
    frm(256, 1, mk("R10 soft mute", 3, 0, 1, 0, 7));
    soft_mute = 1'b0;
    frm(256, 1, mk("R10 soft mute released", 3, 0, 0, 0, 7));
    frm(384, 0, nx);
    frm(384, 1, mk("R4 single new reading", 3, 0, 0, 0, 7));
    frm(384, 1, mk("R9 restart on 384", 4, 0, 1, 1, 0));
    frm(128, 0, nx);
    frm(128, 1, mk("R4 pending 128", 4, 0, 1, 1, 0));
    frm(128, 1, mk("R9 R2 lock 128 restarts", 1, 1, 1, 1, 0));
    for (int i = 0; i < 10; i++) frm(128, 0, nx);
    frm(128, 1, mk("R9 R8 run eleven frames after lock", 1, 1, 0, 0, 7));
    frm(192, 0, nx);
    frm(192, 0, nx);
    frm(192, 1, mk("R2 lock 192", 2, 1, 1, 1, 0));
    frm(512, 0, nx);
    frm(512, 0, nx);
    frm(512, 1, mk("R1 lock 512", 5, 0, 1, 1, 0));
    frm(1000, 0, nx);
    frm(1000, 0, nx);
    frm(1000, 1, mk("R11 R3 invalid lock to idle", 0, 0, 1, 1, 0));
    frm(256, 0, nx);
    frm(256, 0, nx);
    frm(256, 1, mk("R1 relock 256", 3, 0, 1, 1, 0));
    repeat (1200) @(negedge mclk);
    expect_now(mk("R12 one stall window mutes", 3, 0, 1, 1, 0));
    repeat (1000) @(negedge mclk);
    expect_now(mk("R12 two stall windows unlock", 0, 0, 1, 1, 0));
    frm(256, 0, nx);
    frm(256, 0, nx);
    frm(256, 1, mk("R1 relock after stall", 3, 0, 1, 1, 0));
    rst = 1'b1;
    repeat (3) @(negedge mclk);
    expect_now(mk("R6 reset clears lock", 0, 0, 1, 0, 0));
    rst = 1'b0;
    frm(256, 1, mk("R6 idle after reset", 0, 0, 1, 1, 0));
    repeat (10) @(negedge mclk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge mclk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule